// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Register

This block holds the accumulated exception status of a group of floating-point units. There are seven flags: invalid operation, overflow, underflow, inexact, divide-by-zero, input-operand-flushed-to-zero and result-flushed-to-zero. Each unit presents a flag vector and a valid bit in the cycle its result is written back. The register takes the OR of every valid vector and its own stored contents at that clock edge. A flag that has been raised stays raised until software replaces the whole register through the write port.

The valid bit of each unit is the guard of its operation. When the guard is false, that unit's vector is discarded. If several units retire in the same cycle, their vectors are merged. A software write in the same cycle as unit updates does not lose those updates: they are ORed into the written value. The read port shows the stored value from the register.

Top module: `fx_flag_status`

## Requirements
- R1: While `rst` is high at a rising edge, all seven stored flags become 0, and `rd_data` reads 0 in the following cycle.
- R2: A unit update whose valid bit is 1 ORs its flag vector into the stored flags at that rising edge. The new value is visible on `rd_data` right after that edge.
- R3: With `wr_en` low, no stored flag ever goes from 1 to 0, however many updates arrive, including all-zero vectors.
- R4: A unit whose valid bit is 0 has no effect on the stored flags, whatever its flag vector holds.
- R5: When several units are valid in the same cycle, each stored bit becomes the OR of its old value and that bit from every valid vector.
- R6: With `wr_en` high and no valid update, the stored flags become exactly `wr_data`. This is the only way to clear a flag.
- R7: With `wr_en` high and valid unit updates in the same cycle, the stored flags become `wr_data` ORed with all the valid vectors.
- R8: The flag layout in `wr_data`, `rd_data` and every unit vector is: bit 0 invalid, bit 1 overflow, bit 2 underflow, bit 3 inexact, bit 4 divide-by-zero, bit 5 input flushed to zero, bit 6 result flushed to zero. Unit k occupies bits [7k+6:7k] of `upd_flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | NUM_UNITS | Per-unit update valid (guard) bit |
| upd_flags | input | 7*NUM_UNITS | Concatenated per-unit flag vectors, unit 0 in the low bits |
| wr_en | input | 1 | Software write enable |
| wr_data | input | 7 | Value to place in the register on a write |
| rd_data | output | 7 | Current stored flags |

## Verification
Two functions can fall on the same edge. A software write can coincide with unit updates, and several unit updates can coincide with each other. The bench drives a write that clears some bits in the same cycle as valid vectors that set other bits. It checks that the read value is exactly the written value ORed with those vectors. It also raises three or four valid units at once, with one extra unit invalid and carrying bits that must not appear. The read value is then compared against the OR computed by hand from the requirements.

// File: rtl/fx_flag_pkg.sv
package fx_flag_pkg;

    localparam int FLAG_W = 7;

    // Field order is fixed: invalid ends up in bit 0, result-flushed in bit 6.
    typedef struct packed {
        logic res_flush;
        logic in_flush;
        logic div_zero;
        logic inexact;
        logic underflow;
        logic overflow;
        logic invalid;
    } fx_flags_t;

    localparam fx_flags_t FLAGS_CLEAR = '0;

    function automatic fx_flags_t flags_or(input fx_flags_t a, input fx_flags_t b);
        return fx_flags_t'(a | b);
    endfunction

    function automatic fx_flags_t flags_gate(input fx_flags_t f, input logic en);
        return en ? f : FLAGS_CLEAR;
    endfunction

endpackage

// File: rtl/fx_flag_merge.sv
module fx_flag_merge
    import fx_flag_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input  logic [NUM_UNITS-1:0]        upd_valid,
    input  logic [NUM_UNITS*FLAG_W-1:0] upd_flags,
    output fx_flags_t                   merged,
    output logic                        any_valid
);

    fx_flags_t gated [NUM_UNITS];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign gated[u] = flags_gate(fx_flags_t'(upd_flags[u*FLAG_W +: FLAG_W]), upd_valid[u]);
    end

    always_comb begin
        merged = FLAGS_CLEAR;
        for (int u = 0; u < NUM_UNITS; u++) begin
            merged = flags_or(merged, gated[u]);
        end
    end

    assign any_valid = |upd_valid;

endmodule

// File: rtl/fx_flag_store.sv
module fx_flag_store
    import fx_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  fx_flags_t wr_value,
    input  fx_flags_t merged,
    input  logic      any_valid,
    output fx_flags_t stored
);

    fx_flags_t nxt;

    always_comb begin
        nxt = stored;
        if (wr_en) begin
            nxt = flags_or(wr_value, merged);
        end else if (any_valid) begin
            nxt = flags_or(stored, merged);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= FLAGS_CLEAR;
        end else begin
            stored <= nxt;
        end
    end

endmodule

// File: rtl/fx_flag_status.sv
module fx_flag_status
    import fx_flag_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_UNITS-1:0]        upd_valid,
    input  logic [NUM_UNITS*FLAG_W-1:0] upd_flags,
    input  logic                        wr_en,
    input  logic [FLAG_W-1:0]           wr_data,
    output logic [FLAG_W-1:0]           rd_data
);

    fx_flags_t merged;
    logic      any_valid;
    fx_flags_t stored;

    fx_flag_merge #(.NUM_UNITS(NUM_UNITS)) u_merge (
        .upd_valid (upd_valid),
        .upd_flags (upd_flags),
        .merged    (merged),
        .any_valid (any_valid)
    );

    fx_flag_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_value  (fx_flags_t'(wr_data)),
        .merged    (merged),
        .any_valid (any_valid),
        .stored    (stored)
    );

    assign rd_data = stored;

endmodule

// File: rtl/fx_flag_status_chk.sv
module fx_flag_status_chk
    import fx_flag_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_UNITS-1:0]        upd_valid,
    input logic [NUM_UNITS*FLAG_W-1:0] upd_flags,
    input logic                        wr_en,
    input logic [FLAG_W-1:0]           wr_data,
    input logic [FLAG_W-1:0]           rd_data
);

    // Bits that valid units may raise this cycle.
    logic [FLAG_W-1:0] allowed;
    always_comb begin
        allowed = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (upd_valid[u]) allowed = allowed | upd_flags[u*FLAG_W +: FLAG_W];
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> rd_data == '0);

    assert_no_clear_without_write_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((rd_data & $past(rd_data)) == $past(rd_data)));

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && upd_valid == '0) |=> $stable(rd_data));

    assert_only_valid_bits_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ((rd_data & ~$past(rd_data) & ~$past(allowed)) == '0));

    assert_valid_bits_land_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rd_data & $past(allowed)) == $past(allowed)));

    assert_write_replace_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && upd_valid == '0) |=> rd_data == $past(wr_data));

    assert_write_merge_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == ($past(wr_data) | $past(allowed)));

endmodule

bind fx_flag_status fx_flag_status_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_flags (upd_flags),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
);

// File: tb/test_fx_flag_status.sv
module test_fx_flag_status;

    localparam int N  = 4;
    localparam int FW = 7;

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    upd_valid;
    logic [N*FW-1:0] upd_flags;
    logic            wr_en;
    logic [FW-1:0]   wr_data;
    logic [FW-1:0]   rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    fx_flag_status #(.NUM_UNITS(N)) i_fx_flag_status (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_flags(upd_flags),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [FW-1:0] exp);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%b expected=%b", req, rd_data, exp);
        end
    endtask

    task automatic idle_inputs();
        upd_valid = '0; upd_flags = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    // Inputs set at negedge, one rising edge, inputs cleared and sampled at negedge.
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic set_unit(input int u, input logic v, input logic [FW-1:0] f);
        upd_valid[u] = v;
        upd_flags[u*FW +: FW] = f;
    endtask

    task automatic do_write(input logic [FW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        cycle();
    endtask

    task automatic t_reset();
        upd_flags = '1; upd_valid = '0; wr_en = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle_inputs();
        check("R1 reset value", 7'b0);
    endtask

    task automatic t_single();
        set_unit(2, 1'b1, 7'b0000010);          // overflow only
        cycle();
        check("R2 single unit update / R8 overflow is bit 1", 7'b0000010);
        set_unit(0, 1'b1, 7'b0001000);          // inexact only
        cycle();
        check("R2 second update ORs in / R8 inexact is bit 3", 7'b0001010);
    endtask

    task automatic t_sticky();
        for (int k = 0; k < 5; k++) cycle();
        check("R3 idle cycles keep flags", 7'b0001010);
        set_unit(1, 1'b1, 7'b0000000);
        set_unit(3, 1'b1, 7'b0000001);
        cycle();
        check("R3 zero and other-bit updates keep flags", 7'b0001011);
    endtask

    task automatic t_guard();
        set_unit(0, 1'b0, 7'b1111111);
        set_unit(3, 1'b0, 7'b1110100);
        cycle();
        check("R4 invalid updates ignored", 7'b0001011);
    endtask

    task automatic t_clear();
        do_write(7'b0000000);
        check("R6 write clears all", 7'b0000000);
        do_write(7'b1010101);
        check("R6 write replaces", 7'b1010101);
        do_write(7'b0000100);
        check("R6 write clears set bits", 7'b0000100);
    endtask

    task automatic t_multi();
        do_write(7'b0);
        set_unit(0, 1'b1, 7'b0000001);
        set_unit(1, 1'b1, 7'b0010000);
        set_unit(2, 1'b0, 7'b0100000);          // guard false
        set_unit(3, 1'b1, 7'b1000001);
        cycle();
        check("R5 three units merged, R4 fourth ignored", 7'b1010001);
        set_unit(0, 1'b1, 7'b0000100);
        set_unit(1, 1'b1, 7'b0000100);
        set_unit(2, 1'b1, 7'b0100000);
        set_unit(3, 1'b1, 7'b0001000);
        cycle();
        check("R5 four units merged with stored", 7'b1111101);
    endtask

    task automatic t_write_and_update();
        wr_en = 1'b1; wr_data = 7'b0000010;
        set_unit(1, 1'b1, 7'b0100000);
        set_unit(2, 1'b1, 7'b0000001);
        set_unit(0, 1'b0, 7'b1000000);
        cycle();
        check("R7 write merged with same-cycle updates", 7'b0100011);
    endtask

    task automatic t_layout();
        for (int b = 0; b < FW; b++) begin
            do_write(7'b0);
            set_unit(b % N, 1'b1, 7'(1 << b));
            cycle();
            check($sformatf("R8 flag bit %0d from unit %0d", b, b % N), 7'(1 << b));
        end
    endtask

    task automatic t_reset_mid();
        do_write(7'b1111111);
        rst = 1'b1;
        set_unit(0, 1'b1, 7'b0000001);
        cycle();
        rst = 1'b0;
        check("R1 reset overrides stored flags and updates", 7'b0);
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_sticky();
        t_guard();
        t_clear();
        t_multi();
        t_write_and_update();
        t_layout();
        t_reset_mid();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule